// File: doc/BRIEF.md
# Three-Phase Half-Bridge Dead-Time Interlock

This block sits between a motor-control PWM generator and the gate drivers of a three-phase inverter bridge. Each of the three phases takes a low-side command and an active-low high-side command. It produces two registered gate-enable outputs, one for the low switch and one for the high switch. The block settles conflicting commands with fixed priority rules. It also keeps both switches of a phase off for a programmed number of clock cycles before either one turns on, so the bridge never shorts its supply through one leg.

All outputs are cleared at once by a shared disable input or a shared undervoltage flag. A shared bypass-mode input removes the interlock, and each output then follows its own command without delay. In normal operation, turning an output off takes one register stage after synchronization. Turning an output on waits until its request has been held for the programmed dead time. A request that drops before then restarts the wait. A single PWM line can drive both commands of one phase, and the dead time then separates the two switches on every edge.

Top module: `dt_interlock_top`

## Requirements
- R1: While the synchronized disable input is high, every low-side and high-side gate output is 0, whatever the command inputs are.
- R2: While the synchronized undervoltage flag is high, every gate output is 0.
- R3: In interlock mode (bypass input 0), a phase whose low-side command is 1 requests its low-side output on and keeps its high-side output off, whatever its high-side command is.
- R4: The high-side command is active low. In interlock mode, low-side command 0 with high-side command 0 requests the high side on and the low side off. Low-side command 0 with high-side command 1 turns both outputs off.
- R5: Turn-off is immediate. When a command change at the ports removes a request, the output reads 0 after the third rising clock edge following the change (two synchronizer stages plus the output register).
- R6: Turn-on is delayed. With dead-time count D, an output whose request becomes 1 reads 0 after the (max(D,1)+2)-th rising edge and reads 1 after the (max(D,1)+3)-th, provided the request is held throughout.
- R7: Each output has its own turn-on counter, which restarts whenever its request drops. A request pulse shorter than max(D,1)+1 cycles never turns the output on.
- R8: In bypass mode, each output follows its own decoded command (low side = low command, high side = inverted high command) three rising edges after a port change. Both outputs of a phase may then be 1 together.
- R9: In interlock mode, a dead-time count of 0 gives exactly the same timing as a count of 1, so at least one cycle always separates the two switches of a phase.
- R10: A synchronous active-high reset drives all six outputs to 0 and clears all counters.
- R11: When one phase's two commands are tied to a single PWM line, in interlock mode the two outputs of that phase are never 1 together. Between one switch turning off and the other turning on, both outputs stay 0 for at least max(D,1) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_cmd | input | PHASES (3) | Low-side command per phase, active high |
| hi_cmd_n | input | PHASES (3) | High-side command per phase, active low |
| disable_in | input | 1 | Global disable, forces all outputs off |
| uv_flag | input | 1 | Undervoltage flag, forces all outputs off |
| bypass | input | 1 | 1 selects bypass mode (no interlock, no delay) |
| dead_cycles | input | DT_W (16) | Dead-time count in clock cycles |
| lo_gate | output | PHASES (3) | Low-side gate enable per phase |
| hi_gate | output | PHASES (3) | High-side gate enable per phase |

## Verification
A corrupted turn-on counter shows up at the ports as a gate that rises one or more cycles early or late relative to the programmed dead time. The per-clock comparison against the behavioural model catches that in the very cycle the edge is misplaced. A wrong priority or a wrong polarity decode shows up within three edges of the command change as a wrong output, or as both gates of a phase high together in interlock mode. Directed latency probes pin down the exact edge of each turn-on and turn-off, and a short-pulse probe shows a counter that failed to restart as a spurious gate pulse.

// File: rtl/dti_pkg.sv
package dti_pkg;

    localparam int DEF_PHASES = 3;
    localparam int DEF_DT_W   = 16;

    typedef struct packed {
        logic lo;
        logic hi_n;
    } phase_cmd_t;

    typedef struct packed {
        logic lo;
        logic hi;
    } gate_req_t;

    typedef enum logic {
        MODE_INTERLOCK = 1'b0,
        MODE_BYPASS    = 1'b1
    } dt_mode_e;

    // Decode one phase's commands into on-requests for its two switches.
    function automatic gate_req_t resolve_req(phase_cmd_t c, logic kill, dt_mode_e m);
        gate_req_t r;
        r.lo = c.lo & ~kill;
        if (m == MODE_BYPASS)
            r.hi = ~c.hi_n & ~kill;
        else
            r.hi = ~c.hi_n & ~c.lo & ~kill;
        return r;
    endfunction

endpackage

// File: rtl/dti_sync.sv
module dti_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dti_ondelay.sv
module dti_ondelay #(
    parameter int DT_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req,
    input  logic            direct,
    input  logic [DT_W-1:0] dead,
    output logic            out
);
    logic [DT_W-1:0] cnt;
    logic [DT_W-1:0] eff;

    // A zero count still leaves one cycle of separation.
    assign eff = (dead == '0) ? DT_W'(1) : dead;

    always_ff @(posedge clk) begin
        if (rst) begin
            out <= 1'b0;
            cnt <= '0;
        end else if (!req) begin
            out <= 1'b0;
            cnt <= '0;
        end else if (direct) begin
            out <= 1'b1;
            cnt <= '0;
        end else if (!out) begin
            if (cnt >= eff)
                out <= 1'b1;
            else
                cnt <= cnt + DT_W'(1);
        end
    end
endmodule

// File: rtl/dti_phase.sv
module dti_phase
    import dti_pkg::*;
#(
    parameter int DT_W = DEF_DT_W
) (
    input  logic            clk,
    input  logic            rst,
    input  phase_cmd_t      cmd,
    input  logic            kill,
    input  dt_mode_e        mode,
    input  logic [DT_W-1:0] dead,
    output logic            lo_en,
    output logic            hi_en
);
    gate_req_t req;
    logic      direct;

    assign req    = resolve_req(cmd, kill, mode);
    assign direct = (mode == MODE_BYPASS);

    dti_ondelay #(.DT_W(DT_W)) u_lo (
        .clk(clk), .rst(rst), .req(req.lo), .direct(direct),
        .dead(dead), .out(lo_en)
    );

    dti_ondelay #(.DT_W(DT_W)) u_hi (
        .clk(clk), .rst(rst), .req(req.hi), .direct(direct),
        .dead(dead), .out(hi_en)
    );
endmodule

// File: rtl/dt_interlock_top.sv
module dt_interlock_top
    import dti_pkg::*;
#(
    parameter int PHASES = DEF_PHASES,
    parameter int DT_W   = DEF_DT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PHASES-1:0] lo_cmd,
    input  logic [PHASES-1:0] hi_cmd_n,
    input  logic              disable_in,
    input  logic              uv_flag,
    input  logic              bypass,
    input  logic [DT_W-1:0]   dead_cycles,
    output logic [PHASES-1:0] lo_gate,
    output logic [PHASES-1:0] hi_gate
);
    localparam int SW = 2 * PHASES + 3;
    // Safe reset: lows off, highs off (active low = 1), disabled, undervoltage, interlock.
    localparam logic [SW-1:0] SYNC_RST = {{PHASES{1'b0}}, {PHASES{1'b1}}, 3'b110};

    logic [SW-1:0]     raw_in;
    logic [SW-1:0]     sync_out;
    logic [PHASES-1:0] lo_q;
    logic [PHASES-1:0] hi_n_q;
    logic              dis_q;
    logic              uv_q;
    logic              byp_q;
    logic              kill;
    dt_mode_e          mode;

    assign raw_in = {lo_cmd, hi_cmd_n, disable_in, uv_flag, bypass};

    dti_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst(rst), .d(raw_in), .q(sync_out)
    );

    assign {lo_q, hi_n_q, dis_q, uv_q, byp_q} = sync_out;
    assign kill = dis_q | uv_q;
    assign mode = byp_q ? MODE_BYPASS : MODE_INTERLOCK;

    for (genvar g = 0; g < PHASES; g++) begin : g_phase
        phase_cmd_t cmd_g;
        assign cmd_g.lo   = lo_q[g];
        assign cmd_g.hi_n = hi_n_q[g];

        dti_phase #(.DT_W(DT_W)) u_phase (
            .clk(clk), .rst(rst), .cmd(cmd_g), .kill(kill), .mode(mode),
            .dead(dead_cycles), .lo_en(lo_gate[g]), .hi_en(hi_gate[g])
        );
    end
endmodule

// File: rtl/dti_checker.sv
module dti_checker #(
    parameter int PHASES = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              dis_q,
    input logic              uv_q,
    input logic              byp_q,
    input logic [PHASES-1:0] lo_gate,
    input logic [PHASES-1:0] hi_gate
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (lo_gate == '0 && hi_gate == '0)); // R10

    AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (rst)
        $past(dis_q) |-> (lo_gate == '0 && hi_gate == '0)); // R1

    AST_UNDERVOLT_OFF: assert property (@(posedge clk) disable iff (rst)
        $past(uv_q) |-> (lo_gate == '0 && hi_gate == '0)); // R2

    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (rst)
        (!byp_q && !$past(byp_q)) |-> ((lo_gate & hi_gate) == '0)); // R11

    for (genvar p = 0; p < PHASES; p++) begin : g_gap
        AST_HI_GAP: assert property (@(posedge clk) disable iff (rst)
            ($rose(hi_gate[p]) && !$past(byp_q)) |-> !$past(lo_gate[p])); // R6
        AST_LO_GAP: assert property (@(posedge clk) disable iff (rst)
            ($rose(lo_gate[p]) && !$past(byp_q)) |-> !$past(hi_gate[p])); // R6
    end
endmodule

bind dt_interlock_top dti_checker #(.PHASES(PHASES)) u_chk (
    .clk(clk), .rst(rst), .dis_q(dis_q), .uv_q(uv_q), .byp_q(byp_q),
    .lo_gate(lo_gate), .hi_gate(hi_gate)
);

// File: tb/tb_dt_interlock_top.sv
module tb_dt_interlock_top;
    localparam int P = 3;

    logic         clk = 0;
    logic         rst = 1;
    logic [P-1:0] lo_cmd = '0;
    logic [P-1:0] hi_cmd_n = '1;
    logic         disable_in = 0;
    logic         uv_flag = 0;
    logic         bypass = 0;
    logic [15:0]  dead_cycles = 16'd4;
    logic [P-1:0] lo_gate, hi_gate;

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    bit    finished = 0;
    string tag = "R10";

    always #2 clk = ~clk;

    dt_interlock_top dut (
        .clk(clk), .rst(rst), .lo_cmd(lo_cmd), .hi_cmd_n(hi_cmd_n),
        .disable_in(disable_in), .uv_flag(uv_flag), .bypass(bypass),
        .dead_cycles(dead_cycles), .lo_gate(lo_gate), .hi_gate(hi_gate)
    );

    // Behavioural reference: two-stage input delay, then per-output run counters.
    int m_lo[$], m_hn[$];
    int m_dis[$], m_uv[$], m_byp[$];
    int run_lo[P], run_hi[P];
    bit out_lo[P], out_hi[P];

    function automatic void m_reset();
        m_lo  = '{0, 0};
        m_hn  = '{7, 7};
        m_dis = '{1, 1};
        m_uv  = '{1, 1};
        m_byp = '{0, 0};
        for (int i = 0; i < P; i++) begin
            run_lo[i] = 0; run_hi[i] = 0; out_lo[i] = 0; out_hi[i] = 0;
        end
    endfunction

    function automatic void m_step_out(int i, bit rq, bit byp, int eff, ref int run, ref bit o);
        if (!rq) begin o = 0; run = 0; end
        else if (byp) begin o = 1; run = 0; end
        else if (!o) begin
            if (run >= eff) o = 1; else run++;
        end
    endfunction

    initial m_reset();

    always @(posedge clk) begin
        if (rst) m_reset();
        else begin
            int lo_v, hn_v, eff;
            bit kill, byp;
            lo_v = m_lo[0]; hn_v = m_hn[0];
            kill = (m_dis[0] != 0) || (m_uv[0] != 0);
            byp  = (m_byp[0] != 0);
            eff  = (dead_cycles == 0) ? 1 : int'(dead_cycles);
            for (int i = 0; i < P; i++) begin
                bit lc, hc, rl, rh;
                lc = lo_v[i];
                hc = !hn_v[i];
                rl = lc && !kill;
                rh = hc && !kill && (byp || !lc);
                m_step_out(i, rl, byp, eff, run_lo[i], out_lo[i]);
                m_step_out(i, rh, byp, eff, run_hi[i], out_hi[i]);
            end
            void'(m_lo.pop_front());  m_lo.push_back(int'(lo_cmd));
            void'(m_hn.pop_front());  m_hn.push_back(int'(hi_cmd_n));
            void'(m_dis.pop_front()); m_dis.push_back(int'(disable_in));
            void'(m_uv.pop_front());  m_uv.push_back(int'(uv_flag));
            void'(m_byp.pop_front()); m_byp.push_back(int'(bypass));
        end
    end

    // Per-cycle comparison at the falling edge.
    always @(negedge clk) begin
        if (!finished) begin
            logic [P-1:0] el, eh;
            for (int i = 0; i < P; i++) begin el[i] = out_lo[i]; eh[i] = out_hi[i]; end
            total++;
            if (lo_gate !== el || hi_gate !== eh) begin
                bad++;
                $display("FAIL %s cycle %0d: lo=%b hi=%b expected lo=%b hi=%b",
                         tag, cyc, lo_gate, hi_gate, el, eh);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !finished) begin
            bad++;
            $display("FAIL watchdog expired: actual=hung expected=done");
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic probe(string t, bit act, bit exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s probe: actual=%b expected=%b", t, act, exp);
        end
    endtask

    task automatic edges_then_sample(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        // R10: reset state
        tag = "R10";
        wait_cycles(4);
        probe("R10", |{lo_gate, hi_gate}, 1'b0);
        rst = 0;
        wait_cycles(6);

        // R6 / R5 directed latency, dead = 4 -> on after edge 7, off after edge 3
        tag = "R6";
        dead_cycles = 16'd4;
        lo_cmd[0] = 1;
        edges_then_sample(6);
        probe("R6 before", lo_gate[0], 1'b0);
        edges_then_sample(1);
        probe("R6 at", lo_gate[0], 1'b1);
        tag = "R5";
        lo_cmd[0] = 0;
        edges_then_sample(2);
        probe("R5 before", lo_gate[0], 1'b1);
        edges_then_sample(1);
        probe("R5 at", lo_gate[0], 1'b0);
        wait_cycles(10);

        // R3: low command wins over active high command
        tag = "R3";
        lo_cmd = 3'b011; hi_cmd_n = 3'b000;
        wait_cycles(12);
        probe("R3 lo", lo_gate[1], 1'b1);
        probe("R3 hi", hi_gate[1], 1'b0);

        // R4: active-low high command decode
        tag = "R4";
        lo_cmd = 3'b000; hi_cmd_n = 3'b010;
        wait_cycles(12);
        probe("R4 on", hi_gate[0], 1'b1);
        probe("R4 off", hi_gate[1] | lo_gate[1], 1'b0);

        // R11: tied PWM, dead = 6, both off in the gap
        tag = "R11";
        dead_cycles = 16'd6;
        lo_cmd = 3'b111; hi_cmd_n = 3'b111;
        wait_cycles(14);
        lo_cmd[2] = 0; hi_cmd_n[2] = 0;
        edges_then_sample(5);
        probe("R11 gap", lo_gate[2] | hi_gate[2], 1'b0);
        for (int k = 0; k < 6; k++) begin
            wait_cycles(3 + 2 * k);
            lo_cmd = ~lo_cmd; hi_cmd_n = lo_cmd;
        end
        wait_cycles(16);

        // R7: short request pulses never turn an output on
        tag = "R7";
        lo_cmd = '0; hi_cmd_n = '1;
        wait_cycles(12);
        lo_cmd[1] = 1;
        wait_cycles(6);
        lo_cmd[1] = 0;
        begin
            bit seen = 0;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (lo_gate[1]) seen = 1;
            end
            probe("R7 glitch", seen, 1'b0);
        end

        // R9: dead count 0 behaves as 1 (on after edge 4)
        tag = "R9";
        dead_cycles = 16'd0;
        hi_cmd_n[2] = 0;
        edges_then_sample(3);
        probe("R9 before", hi_gate[2], 1'b0);
        edges_then_sample(1);
        probe("R9 at", hi_gate[2], 1'b1);
        for (int k = 0; k < 5; k++) begin
            wait_cycles(2 + k);
            lo_cmd = ~lo_cmd; hi_cmd_n = lo_cmd;
        end
        wait_cycles(8);

        // R8: bypass, both switches on, three edges
        tag = "R8";
        dead_cycles = 16'd200;
        bypass = 1;
        lo_cmd = '0; hi_cmd_n = '1;
        wait_cycles(6);
        lo_cmd = 3'b101; hi_cmd_n = 3'b010;
        edges_then_sample(2);
        probe("R8 before", lo_gate[0], 1'b0);
        edges_then_sample(1);
        probe("R8 lo", lo_gate[0], 1'b1);
        probe("R8 hi", hi_gate[0], 1'b1);
        wait_cycles(5);
        bypass = 0;
        wait_cycles(10);
        dead_cycles = 16'd3;

        // R1: disable forces all off
        tag = "R1";
        lo_cmd = 3'b001; hi_cmd_n = 3'b001;
        wait_cycles(12);
        disable_in = 1;
        edges_then_sample(3);
        probe("R1", |{lo_gate, hi_gate}, 1'b0);
        wait_cycles(5);
        disable_in = 0;
        wait_cycles(12);

        // R2: undervoltage forces all off
        tag = "R2";
        uv_flag = 1;
        edges_then_sample(3);
        probe("R2", |{lo_gate, hi_gate}, 1'b0);
        wait_cycles(4);
        uv_flag = 0;
        wait_cycles(12);

        // R10: reset in the middle of operation
        tag = "R10";
        rst = 1;
        edges_then_sample(1);
        probe("R10 mid", |{lo_gate, hi_gate}, 1'b0);
        rst = 0;
        wait_cycles(12);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule